// File: doc/BRIEF.md
# Scaled Normalized LMS Noise Canceller

This block removes an interference component from a sampled signal. Each sample brings two 12-bit unsigned converter codes, read as integers from 0 to 4095. The primary code carries the wanted signal plus interference. The reference code carries only a correlated copy of the interference. The reference codes pass through a short delay line into an adaptive FIR filter. The filter's estimate is subtracted from the primary code, and the difference is the cleaned sample.

The filter adapts with a normalized LMS rule in pure integer arithmetic. The weights are kept multiplied by 2^12, so that small corrections survive in 16-bit signed storage. The output sum is shifted back down by 12. The correction for each sample is the error times a fixed step, divided by the energy of the delay line. One restoring sequential divider forms this factor once per sample, and a second pass then applies it to every tap. The cleaned sample is also given as a converter word: it is shifted down by 4, offset by 750 and clamped to the 12-bit range.

A strobe starts a sample. The block reports busy until it finishes, and then gives a one-cycle done pulse with both results.

Top module: `snlms_canceller`

## Requirements
- R1: A strobe on `smp_vld` while `busy` is low starts a sample, and `busy` is high after that edge. Strobes that arrive while `busy` is high are ignored: they change neither the current result nor any later one.
- R2: Each accepted sample pushes `ref_code` into the newest of TAPS delay-line taps (4 by default) and drops the oldest. Codes are treated as non-negative integers.
- R3: With h the stored weights and x the delay line, y = (sum of h_i·x_i) shifted right arithmetically by 12. The error e = pri_code − y is saturated to the signed 16-bit range and is given on `err_smp`.
- R4: The norm is the sum of x_i² over all taps, including the new sample. The step factor g = (e·2^(13−MU_SH)) / norm, truncated toward zero. With the default MU_SH = 4 this is e·512/norm.
- R5: After the output is formed, each weight becomes h_i + g·x_i, saturated to −32768..32767. All weights are 0 after reset.
- R6: When the norm is zero, no division is done and the weights are left unchanged. `done` is then high TAPS+2 clock edges after the accepting edge.
- R7: When the norm is non-zero, `done` is high 2·TAPS+NUM_W+3 clock edges after the accepting edge (43 by default).
- R8: `dac_code` = clamp((e >>> 4) + 750, 0, 4095).
- R9: `done` is a single-cycle pulse. `busy` is low while `done` is high. `err_smp` and `dac_code` change only together with `done`.
- R10: After reset, `busy`, `done`, `err_smp` and `dac_code` are all 0, and the delay line and weights are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample strobe |
| pri_code | input | 12 | Primary input code (signal plus interference) |
| ref_code | input | 12 | Reference input code (interference only) |
| busy | output | 1 | High while a sample is in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| err_smp | output | 16 | Cleaned sample e, signed |
| dac_code | output | 12 | Offset, down-shifted and clamped converter word |

## Verification
The bench drives a reference code of 1 into empty weights with a large primary code, which forces a weight to its positive limit. The following output must be −7. A design that wraps the weight instead of saturating it would give a very different value. Training on a small reference and then switching to full scale drives the error far negative, which exercises both the error saturation and the lower clamp of the converter word; a design that got either wrong would wrap to a large positive word. Zero-energy samples check that the divider is bypassed, with its shorter latency. Extra strobes sent during busy check that a design which accepted them would not corrupt the delay line and so break every later result.

// File: rtl/snlms_pkg.sv
// Shared types for the scaled normalized LMS canceller.
// Holds the sequencing states used by the top-level controller.
package snlms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC,
        ST_ERR,
        ST_DIV,
        ST_UPD,
        ST_FIN
    } snlms_state_e;

endpackage

// File: rtl/snlms_tapline.sv
// Reference delay line of the canceller.
// Shifts a new sample into tap 0 on shift_en, drops the oldest tap, and
// reads one tap selected by rd_idx combinationally.
// Assumes rd_idx < TAPS. All taps reset to zero.
module snlms_tapline #(
    parameter int TAPS  = 4,
    parameter int XW    = 16,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic [XW-1:0]        din,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic signed [XW-1:0] rd_x
);

    logic [XW-1:0] tap_q [TAPS];

    // Newest tap takes the incoming sample.
    always_ff @(posedge clk) begin
        if (!rst_n)        tap_q[0] <= '0;
        else if (shift_en) tap_q[0] <= din;
    end

    // Older taps each take their younger neighbour.
    for (genvar gi = 1; gi < TAPS; gi++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n)        tap_q[gi] <= '0;
            else if (shift_en) tap_q[gi] <= tap_q[gi-1];
        end
    end

    // Tap read port.
    always_comb rd_x = $signed(tap_q[rd_idx]);

endmodule

// File: rtl/snlms_wbank.sv
// Scaled weight storage of the canceller.
// Holds TAPS signed weights. On upd_en, the weight at upd_idx takes
// weight + upd_prod, saturated to the signed WW-bit range.
// Assumes upd_idx and rd_idx < TAPS. Weights reset to zero.
module snlms_wbank #(
    parameter int TAPS  = 4,
    parameter int WW    = 16,
    parameter int PW    = 48,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic signed [PW-1:0] upd_prod,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic signed [WW-1:0] rd_w
);

    localparam logic signed [PW:0] W_HI = (PW+1)'((2**(WW-1)) - 1);
    localparam logic signed [PW:0] W_LO = -W_HI - (PW+1)'(1);

    logic signed [WW-1:0] w_q [TAPS];
    logic signed [WW-1:0] cur_w;
    logic signed [PW:0]   sum_w;
    logic signed [WW-1:0] sat_w;

    // Saturating add of the correction to the addressed weight.
    always_comb begin
        cur_w = w_q[upd_idx];
        sum_w = $signed({{(PW+1-WW){cur_w[WW-1]}}, cur_w}) + $signed({upd_prod[PW-1], upd_prod});
        if (sum_w > W_HI)      sat_w = W_HI[WW-1:0];
        else if (sum_w < W_LO) sat_w = W_LO[WW-1:0];
        else                   sat_w = sum_w[WW-1:0];
    end

    // One register per weight, written only when addressed.
    for (genvar gi = 0; gi < TAPS; gi++) begin : g_w
        always_ff @(posedge clk) begin
            if (!rst_n)                                   w_q[gi] <= '0;
            else if (upd_en && upd_idx == IDX_W'(gi))     w_q[gi] <= sat_w;
        end
    end

    // Weight read port.
    always_comb rd_w = w_q[rd_idx];

    // R5
    wgt_sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_prod[PW-1]) |=> (w_q[$past(upd_idx)] >= $past(cur_w)));

    // R5
    wgt_sat_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_prod[PW-1]) |=> (w_q[$past(upd_idx)] <= $past(cur_w)));

endmodule

// File: rtl/snlms_div.sv
// Restoring sequential divider, signed numerator by unsigned divisor.
// Loads on start and produces one quotient bit per clock for NUM_W clocks.
// It then pulses done for one cycle. The quotient is truncated toward zero.
// Assumes den_i is non-zero when start is given and that start is not
// given while busy.
module snlms_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0]        den_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic signed [NUM_W-1:0] quo_o
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_q;
    logic [DEN_W:0]   r_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             neg_q;
    logic [NUM_W-1:0] num_mag;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;

    // Magnitude of the numerator and one restoring step.
    always_comb begin
        num_mag = num_i[NUM_W-1] ? NUM_W'(-num_i) : NUM_W'(num_i);
        trial   = {r_q[DEN_W-1:0], q_q[NUM_W-1]};
        diff    = trial - {1'b0, den_q};
    end

    // Iteration registers: load on start, then step until the count runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q    <= '0;
            r_q    <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            neg_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start) begin
                q_q   <= num_mag;
                r_q   <= '0;
                den_q <= den_i;
                cnt_q <= CNT_W'(NUM_W);
                neg_q <= num_i[NUM_W-1];
            end else if (cnt_q != '0) begin
                if (!diff[DEN_W]) begin
                    r_q <= diff;
                    q_q <= {q_q[NUM_W-2:0], 1'b1};
                end else begin
                    r_q <= trial;
                    q_q <= {q_q[NUM_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) done_o <= 1'b1;
            end
        end
    end

    // Signed result and activity flag.
    always_comb begin
        busy_o = (cnt_q != '0);
        quo_o  = neg_q ? -$signed(q_q) : $signed(q_q);
    end

    // R6
    div_den_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (den_i != '0));

    // R4
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (r_q < {1'b0, den_q}));

endmodule

// File: rtl/snlms_canceller.sv
// Scaled normalized LMS adaptive noise canceller, top level.
// Per accepted strobe: shifts the reference code into the delay line,
// accumulates h.x and |x|^2 one tap per clock, and forms the saturated
// error. It divides the scaled error by the norm (skipped when the norm
// is zero) and applies the factor to every weight. Finally it publishes
// the error and the converter word with a one-cycle done pulse.
// Assumes the input codes are unsigned integers. Strobes are ignored while busy.
module snlms_canceller #(
    parameter int TAPS     = 4,
    parameter int DW       = 16,
    parameter int CODE_W   = 12,
    parameter int SCALE_SH = 12,
    parameter int MU_SH    = 4,
    parameter int OUT_SH   = 4,
    parameter int OUT_OFS  = 750,
    parameter int NORM_W   = 32,
    parameter int NUM_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [CODE_W-1:0] pri_code,
    input  logic [CODE_W-1:0] ref_code,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     err_smp,
    output logic [CODE_W-1:0] dac_code
);
    import snlms_pkg::*;

    localparam int IDX_W    = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam int STEP_SH  = 1 + SCALE_SH - MU_SH;
    localparam int ACC_W    = 2 * DW + IDX_W + 1;
    localparam int PROD_W   = NUM_W + DW;
    localparam int CODE_MAX = (2 ** CODE_W) - 1;
    localparam logic signed [ACC_W:0] E_HI  = (ACC_W+1)'((2**(DW-1)) - 1);
    localparam logic signed [ACC_W:0] E_LO  = -E_HI - (ACC_W+1)'(1);
    localparam logic signed [DW+1:0]  D_HI  = (DW+2)'(CODE_MAX);
    localparam logic signed [DW+1:0]  D_OFS = (DW+2)'(OUT_OFS);

    snlms_state_e             state_q;
    logic [IDX_W-1:0]         idx_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic [NORM_W-1:0]        nrm_q;
    logic [DW-1:0]            d_q;
    logic signed [DW-1:0]     e_q;
    logic signed [NUM_W-1:0]  g_q;
    logic signed [DW-1:0]     err_q;
    logic [CODE_W-1:0]        dac_q;
    logic                     done_q;

    logic signed [DW-1:0]     x_cur;
    logic signed [DW-1:0]     w_cur;
    logic signed [2*DW-1:0]   mac_p;
    logic [2*DW-1:0]          sq_p;
    logic signed [ACC_W-1:0]  y_w;
    logic signed [ACC_W:0]    e_w;
    logic signed [DW-1:0]     e_sat;
    logic signed [NUM_W-1:0]  step_num;
    logic signed [PROD_W-1:0] upd_prod;
    logic signed [DW-1:0]     e_sh;
    logic signed [DW+1:0]     dac_w;
    logic [CODE_W-1:0]        dac_clamped;
    logic                     last_tap;
    logic                     accept;
    logic                     div_start;
    logic                     div_busy;
    logic                     div_done;
    logic signed [NUM_W-1:0]  div_quo;

    // Handshake decode and tap-counter end.
    always_comb begin
        accept    = (state_q == ST_IDLE) && smp_vld;
        last_tap  = (idx_q == IDX_W'(TAPS - 1));
        div_start = (state_q == ST_ERR) && (nrm_q != '0);
    end

    snlms_tapline #(.TAPS(TAPS), .XW(DW), .IDX_W(IDX_W)) i_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (DW'(ref_code)),
        .rd_idx   (idx_q),
        .rd_x     (x_cur)
    );

    snlms_wbank #(.TAPS(TAPS), .WW(DW), .PW(PROD_W), .IDX_W(IDX_W)) i_wbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (state_q == ST_UPD),
        .upd_idx  (idx_q),
        .upd_prod (upd_prod),
        .rd_idx   (idx_q),
        .rd_w     (w_cur)
    );

    snlms_div #(.NUM_W(NUM_W), .DEN_W(NORM_W)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .num_i  (step_num),
        .den_i  (nrm_q),
        .busy_o (div_busy),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    // Per-tap products for the filter sum, the norm and the weight update.
    always_comb begin
        mac_p    = $signed({{DW{x_cur[DW-1]}}, x_cur}) * $signed({{DW{w_cur[DW-1]}}, w_cur});
        sq_p     = {{DW{1'b0}}, x_cur} * {{DW{1'b0}}, x_cur};
        upd_prod = $signed({{DW{g_q[NUM_W-1]}}, g_q}) * $signed({{NUM_W{x_cur[DW-1]}}, x_cur});
    end

    // Unscaled filter output, saturated error and scaled step numerator.
    always_comb begin
        y_w = acc_q >>> SCALE_SH;
        e_w = $signed({{(ACC_W+1-DW){1'b0}}, d_q}) - $signed({y_w[ACC_W-1], y_w});
        if (e_w > E_HI)      e_sat = E_HI[DW-1:0];
        else if (e_w < E_LO) e_sat = E_LO[DW-1:0];
        else                 e_sat = e_w[DW-1:0];
        step_num = $signed({{(NUM_W-DW){e_sat[DW-1]}}, e_sat}) <<< STEP_SH;
    end

    // Converter word: down-shift, offset, clamp.
    always_comb begin
        e_sh  = e_q >>> OUT_SH;
        dac_w = $signed({{2{e_sh[DW-1]}}, e_sh}) + D_OFS;
        if (dac_w[DW+1])     dac_clamped = '0;
        else if (dac_w > D_HI) dac_clamped = CODE_W'(CODE_MAX);
        else                 dac_clamped = dac_w[CODE_W-1:0];
    end

    // Sample sequencer: accumulate, form error, divide, update, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            acc_q   <= '0;
            nrm_q   <= '0;
            d_q     <= '0;
            e_q     <= '0;
            g_q     <= '0;
            err_q   <= '0;
            dac_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (smp_vld) begin
                        d_q     <= DW'(pri_code);
                        acc_q   <= '0;
                        nrm_q   <= '0;
                        idx_q   <= '0;
                        state_q <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    acc_q <= acc_q + $signed({{(ACC_W-2*DW){mac_p[2*DW-1]}}, mac_p});
                    nrm_q <= nrm_q + NORM_W'(sq_p);
                    if (last_tap) begin
                        idx_q   <= '0;
                        state_q <= ST_ERR;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_ERR: begin
                    e_q     <= e_sat;
                    state_q <= (nrm_q == '0) ? ST_FIN : ST_DIV;
                end
                ST_DIV: begin
                    if (div_done) begin
                        g_q     <= div_quo;
                        idx_q   <= '0;
                        state_q <= ST_UPD;
                    end
                end
                ST_UPD: begin
                    if (last_tap) begin
                        idx_q   <= '0;
                        state_q <= ST_FIN;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_FIN: begin
                    err_q   <= e_q;
                    dac_q   <= dac_clamped;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        err_smp  = err_q;
        dac_code = dac_q;
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && smp_vld) |=> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(err_smp) && $stable(dac_code)));

    // R8
    dac_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_smp[DW-1]) |-> (dac_code >= CODE_W'(OUT_OFS)));

    // R7
    div_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV) |-> (div_busy || div_done));

endmodule

// File: tb/test_snlms_canceller.sv
// Self-checking bench: directed corner cases plus seeded random samples,
// compared against a bench-side integer model of the update rule.
module test_snlms_canceller;

    localparam int TAPS  = 4;
    localparam int NUM_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] pri_code = '0;
    logic [11:0] ref_code = '0;
    logic        busy;
    logic        done;
    logic [15:0] err_smp;
    logic [11:0] dac_code;

    int checks = 0;
    int errs   = 0;
    int clamp_hits = 0;

    longint mh [TAPS];
    longint mx [TAPS];

    always #10 clk = ~clk;

    snlms_canceller i_snlms_canceller (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .pri_code(pri_code), .ref_code(ref_code),
        .busy(busy), .done(done), .err_smp(err_smp), .dac_code(dac_code)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Integer model of one sample: returns error, converter word, zero-norm flag.
    function automatic void model_step(input int d, input int r,
                                       output int e_o, output int dac_o, output bit zn_o);
        longint acc, nrm, y, g, dv;
        for (int i = TAPS - 1; i > 0; i--) mx[i] = mx[i-1];
        mx[0] = r;
        acc = 0; nrm = 0;
        for (int i = 0; i < TAPS; i++) begin
            acc += mh[i] * mx[i];
            nrm += mx[i] * mx[i];
        end
        y    = acc >>> 12;
        e_o  = int'(sat16(longint'(d) - y));
        zn_o = (nrm == 0);
        if (!zn_o) begin
            g = (longint'(e_o) * 512) / nrm;
            for (int i = 0; i < TAPS; i++) mh[i] = sat16(mh[i] + g * mx[i]);
        end
        dv = longint'(e_o >>> 4) + 750;
        if (dv < 0) dv = 0;
        if (dv > 4095) dv = 4095;
        dac_o = int'(dv);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_vld = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < TAPS; i++) begin mh[i] = 0; mx[i] = 0; end
        @(negedge clk);
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 err_smp", $signed(err_smp), 0);
        chk("R10 dac_code", dac_code, 0);
    endtask

    // Run one sample; optionally inject an ignored strobe while busy.
    task automatic run_sample(input int d, input int r, input bit inject);
        int e_exp, dac_exp, n;
        bit zn;
        logic [15:0] held;
        model_step(d, r, e_exp, dac_exp, zn);
        @(negedge clk);
        smp_vld = 1'b1; pri_code = 12'(d); ref_code = 12'(r);
        @(negedge clk);
        smp_vld = 1'b0;
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
            if (inject && n == 3) begin
                smp_vld = 1'b1; pri_code = 12'($urandom); ref_code = 12'($urandom);
            end else if (inject && n == 4) begin
                smp_vld = 1'b0;
            end
        end while (!done && n < 200);
        smp_vld = 1'b0;
        if (n >= 200) chk("R7 done timeout", n, 0);
        if (zn) chk("R6 zero-norm latency", n, TAPS + 2);
        else    chk("R7 latency", n, 2 * TAPS + NUM_W + 3);
        chk(inject ? "R1 R2 R3 err_smp (strobe during busy)" : "R2 R3 R4 R5 err_smp",
            $signed(err_smp), e_exp);
        chk("R8 dac_code", dac_code, dac_exp);
        chk("R9 busy low at done", busy, 0);
        if (dac_exp == 0) clamp_hits++;
        held = err_smp;
        @(posedge clk); #1;
        chk("R9 done single pulse", done, 0);
        chk("R9 err_smp held", err_smp, held);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R6: zero energy in the delay line, divider bypassed.
        run_sample(1000, 0, 1'b0);
        chk("R6 err equals primary", $signed(err_smp), 1000);

        // R5: tiny reference pushes a weight into positive saturation.
        run_sample(4095, 1, 1'b0);
        chk("R8 dac for e=4095", dac_code, 1005);
        run_sample(0, 1, 1'b0);
        chk("R5 saturated weight gives e=-7", $signed(err_smp), -7);
        chk("R8 dac for e=-7", dac_code, 749);

        // R8 R3: train on small reference, then full scale to drive e very negative.
        do_reset();
        clamp_hits = 0;
        for (int k = 0; k < 60; k++) run_sample(4095, 200, 1'b0);
        for (int k = 0; k < 6; k++)  run_sample(0, 4095, 1'b0);
        checks++;
        if (clamp_hits == 0) begin
            errs++;
            $display("FAIL R8 lower clamp case not reached actual=%0d expected>0", clamp_hits);
        end

        // R1: strobes during busy are ignored.
        for (int k = 0; k < 8; k++) run_sample(int'($urandom % 4096), int'($urandom % 4096), 1'b1);

        // Random mix of reference ranges.
        do_reset();
        for (int k = 0; k < 300; k++) begin
            int mode, r;
            mode = int'($urandom % 4);
            case (mode)
                0: r = int'($urandom % 4096);
                1: r = int'($urandom % 8);
                2: r = 0;
                default: r = 1800 + int'($urandom % 500);
            endcase
            run_sample(int'($urandom % 4096), r, ($urandom % 8) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule